// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs single register transactions on a two-wire PHY management bus. A host presents one command: read or write, a 5-bit PHY address, a 5-bit register address and, for writes, a 16-bit value. The block then serialises a clause-22-style frame on MDIO, timed by a management clock (MDC) that it derives from the system clock.

The frame starts with a run of ones, followed by the start and opcode fields and the two addresses. A write then carries a driven turnaround and the data word. A read releases the line, lets one clock go by unused, and shifts in the PHY's 16-bit answer. The answer comes back on `rdata` together with a one-cycle `done` pulse.

Only one transaction is in flight at a time. `busy` shows when the block is occupied, and any request made while it is high is dropped.

Top module: `mdio_master`

## Requirements
- R1: While reset is high and in the cycles after it, mdc, mdio_oe, busy and done are 0 and rdata is 0.
- R2: Every frame begins with 34 MDC periods in which MDIO is driven (mdio_oe=1) to 1.
- R3: After the ones come the start bits 0,1 and then the opcode, which is 1,0 for a read (op_read=1) and 0,1 for a write (op_read=0).
- R4: Next comes the PHY address, 5 bits MSB first, then the register address, 5 bits MSB first (frame bit positions 38..47).
- R5: A write frame drives the turnaround as 1 then 0, then wdata MSB first, for 66 MDC pulses in total, with mdio_oe high in every one of them.
- R6: A read frame drives mdio_oe for bits 0..47 only. It ignores the MDIO sample at bit 48 (turnaround), captures bits 49..64 MSB first into rdata, and has 65 MDC pulses.
- R7: Each bit holds MDC low for HALF_PERIOD system cycles and then high for HALF_PERIOD cycles, so busy lasts exactly 2*HALF_PERIOD cycles per bit. mdio_o and mdio_oe change only while MDC is low, and MDC rests low between frames.
- R8: done is high for exactly one cycle, in the first cycle with busy low after a frame. rdata changes only when done is high and only after a read, so writes leave it unchanged.
- R9: A request made while busy is high, including in the cycle of the last MDC falling edge, is ignored. A request made in the done cycle is accepted.
- R10: mdio_oe is low whenever busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Command strobe, taken when idle |
| op_read | input | 1 | 1 = read, 0 = write |
| phy_addr | input | 5 | Target PHY address |
| reg_addr | input | 5 | Target register address |
| wdata | input | 16 | Write value |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Last read result |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
The end of a frame and a new request can fall on the same clock edge. This is provoked by holding a request in the single cycle before the final MDC falling edge, which must be dropped, and then by raising a request in the done cycle itself, which must start a new frame at once. The dropped request is judged by busy staying low and no further MDC pulses appearing. The accepted one is judged by busy rising on the next cycle and a complete, correctly encoded frame following.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int PRE_LEN    = 34;
    localparam int ADDR_W     = 5;
    localparam int DATA_W     = 16;
    localparam int FRAME_W    = PRE_LEN + 4 + 2 * ADDR_W + 2 + DATA_W;
    localparam int RD_TA_BIT  = PRE_LEN + 4 + 2 * ADDR_W;
    localparam int RD_D0_BIT  = RD_TA_BIT + 1;
    localparam int LAST_WR    = FRAME_W - 1;
    localparam int LAST_RD    = RD_D0_BIT + DATA_W - 1;
    localparam int IDX_W      = $clog2(FRAME_W + 1);

    typedef enum logic {OP_WRITE = 1'b0, OP_READ = 1'b1} mdio_op_e;
    typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} mdio_state_e;

    typedef struct packed {
        mdio_op_e            op;
        logic [ADDR_W-1:0]   phy;
        logic [ADDR_W-1:0]   regad;
        logic [DATA_W-1:0]   wdata;
    } mdio_cmd_t;

    function automatic logic [FRAME_W-1:0] build_frame(input mdio_cmd_t c);
        logic [FRAME_W-1:0] f;
        if (c.op == OP_READ)
            f = {{PRE_LEN{1'b1}}, 2'b01, 2'b10, c.phy, c.regad, {(2 + DATA_W){1'b1}}};
        else
            f = {{PRE_LEN{1'b1}}, 2'b01, 2'b01, c.phy, c.regad, 2'b10, c.wdata};
        return f;
    endfunction

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int HALF_PERIOD = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic mdc,
    output logic rise_stb,
    output logic fall_stb
);
    localparam int CNT_W = (HALF_PERIOD > 1) ? $clog2(HALF_PERIOD) : 1;
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(HALF_PERIOD - 1);

    logic [CNT_W-1:0] cnt;
    logic             at_end;

    assign at_end   = run && (cnt == CNT_MAX);
    assign rise_stb = at_end && !mdc;
    assign fall_stb = at_end && mdc;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (at_end) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_txshift.sv
module mdio_txshift
    import mdio_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load,
    input  mdio_cmd_t cmd,
    input  logic      shift,
    output logic      bit_o
);
    logic [FRAME_W-1:0] shreg;

    assign bit_o = shreg[FRAME_W-1];

    always_ff @(posedge clk) begin
        if (rst)
            shreg <= '1;
        else if (load)
            shreg <= build_frame(cmd);
        else if (shift)
            shreg <= {shreg[FRAME_W-2:0], 1'b1};
    end
endmodule

// File: rtl/mdio_rxcapture.sv
module mdio_rxcapture
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              sample,
    input  logic              din,
    output logic [DATA_W-1:0] word
);
    always_ff @(posedge clk) begin
        if (rst || clear)
            word <= '0;
        else if (sample)
            word <= {word[DATA_W-2:0], din};
    end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int HALF_PERIOD = 20
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req,
    input  logic        op_read,
    input  logic [4:0]  phy_addr,
    input  logic [4:0]  reg_addr,
    input  logic [15:0] wdata,
    output logic        busy,
    output logic        done,
    output logic [15:0] rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    localparam logic [IDX_W-1:0] IDX_LAST_WR = IDX_W'(LAST_WR);
    localparam logic [IDX_W-1:0] IDX_LAST_RD = IDX_W'(LAST_RD);
    localparam logic [IDX_W-1:0] IDX_TA      = IDX_W'(RD_TA_BIT);
    localparam logic [IDX_W-1:0] IDX_D0      = IDX_W'(RD_D0_BIT);

    mdio_state_e       state;
    mdio_op_e          op_q;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] rdata_q;
    logic              done_q;

    mdio_cmd_t         cmd_in;
    logic              accept, run, finish, sample, rise_stb, fall_stb, tx_bit;
    logic [DATA_W-1:0] rx_word;
    logic [IDX_W-1:0]  idx_last;

    assign cmd_in   = '{op: mdio_op_e'(op_read), phy: phy_addr, regad: reg_addr, wdata: wdata};
    assign run      = (state == ST_RUN);
    assign accept   = (state == ST_IDLE) && req;
    assign idx_last = (op_q == OP_READ) ? IDX_LAST_RD : IDX_LAST_WR;
    assign finish   = fall_stb && (idx == idx_last);
    assign sample   = rise_stb && (op_q == OP_READ) && (idx >= IDX_D0);

    mdio_clkgen #(.HALF_PERIOD(HALF_PERIOD)) u_clk (
        .clk(clk), .rst(rst), .run(run),
        .mdc(mdc), .rise_stb(rise_stb), .fall_stb(fall_stb)
    );

    mdio_txshift u_tx (
        .clk(clk), .rst(rst), .load(accept), .cmd(cmd_in),
        .shift(fall_stb), .bit_o(tx_bit)
    );

    mdio_rxcapture u_rx (
        .clk(clk), .rst(rst), .clear(accept), .sample(sample),
        .din(mdio_i), .word(rx_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            op_q    <= OP_WRITE;
            idx     <= '0;
            rdata_q <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        state <= ST_RUN;
                        op_q  <= cmd_in.op;
                        idx   <= '0;
                    end
                end
                ST_RUN: begin
                    if (finish) begin
                        state  <= ST_IDLE;
                        done_q <= 1'b1;
                        if (op_q == OP_READ)
                            rdata_q <= rx_word;
                    end else if (fall_stb) begin
                        idx <= idx + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy    = run;
    assign done    = done_q;
    assign rdata   = rdata_q;
    assign mdio_oe = run && !((op_q == OP_READ) && (idx >= IDX_TA));
    assign mdio_o  = mdio_oe && tx_bit;
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic        done,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe,
    input logic [15:0] rdata
);
    p_oe_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mdio_oe);

    p_mdc_rest_r7: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mdc);

    p_stable_high_r7: assert property (@(posedge clk) disable iff (rst)
        (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

    p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_idle_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    p_rdata_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(rdata));
endmodule

bind mdio_master mdio_master_chk u_chk (
    .clk(clk), .rst(rst), .busy(busy), .done(done), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .rdata(rdata)
);

// File: tb/mdio_master_test.sv
module mdio_master_test;
    localparam int HP = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic        op_read = 1'b0;
    logic [4:0]  phy_addr = '0;
    logic [4:0]  reg_addr = '0;
    logic [15:0] wdata = '0;
    logic        busy, done, mdc, mdio_o, mdio_oe;
    logic [15:0] rdata;
    logic        mdio_i = 1'b1;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    mdio_master #(.HALF_PERIOD(HP)) uut (
        .clk(clk), .rst(rst), .req(req), .op_read(op_read),
        .phy_addr(phy_addr), .reg_addr(reg_addr), .wdata(wdata),
        .busy(busy), .done(done), .rdata(rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    // PHY-side observer and responder
    logic        cap_o  [80];
    logic        cap_oe [80];
    int          nrise = 0;
    logic        cur_read = 1'b0;
    logic [15:0] phy_val = '0;
    logic [15:0] last_rd = '0;

    always @(posedge mdc) begin
        if (nrise < 80) begin
            cap_o[nrise]  = mdio_o;
            cap_oe[nrise] = mdio_oe;
        end
        nrise = nrise + 1;
    end

    always @(negedge mdc) begin
        if (cur_read && nrise >= 49 && nrise <= 64)
            mdio_i = phy_val[15 - (nrise - 49)];
        else
            mdio_i = 1'b1;
    end

    // op(1) phy(5) reg(5) data(16): write data, or PHY answer for reads
    localparam logic [26:0] VEC [6] = '{
        {1'b0, 5'h01, 5'h00, 16'h1234},
        {1'b1, 5'h01, 5'h01, 16'h5A3C},
        {1'b0, 5'h1F, 5'h1F, 16'hFFFF},
        {1'b1, 5'h10, 5'h11, 16'h8001},
        {1'b0, 5'h00, 5'h0A, 16'h0000},
        {1'b1, 5'h15, 5'h0A, 16'h0000}
    };

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    function automatic logic exp_bit(input logic op, input logic [4:0] phy,
                                     input logic [4:0] ra, input logic [15:0] d, input int i);
        if (i < 34) return 1'b1;
        if (i == 34) return 1'b0;
        if (i == 35) return 1'b1;
        if (i == 36) return op;
        if (i == 37) return !op;
        if (i < 43) return phy[4 - (i - 38)];
        if (i < 48) return ra[4 - (i - 43)];
        if (i == 48) return 1'b1;
        if (i == 49) return 1'b0;
        return d[15 - (i - 50)];
    endfunction

    task automatic check_frame(input logic op, input logic [4:0] phy,
                               input logic [4:0] ra, input logic [15:0] d);
        int nb = op ? 65 : 66;
        int bpre = 0, bhdr = 0, badr = 0, btail = 0, boe = 0;
        for (int i = 0; i < nb; i++) begin
            logic eoe = op ? (i < 48) : 1'b1;
            if (cap_oe[i] !== eoe) boe++;
            if (eoe && cap_o[i] !== exp_bit(op, phy, ra, d, i)) begin
                if (i < 34) bpre++;
                else if (i < 38) bhdr++;
                else if (i < 48) badr++;
                else btail++;
            end
        end
        chk(bpre == 0, "R2", "preamble bit errors", bpre, 0);
        chk(bhdr == 0, "R3", "start/opcode bit errors", bhdr, 0);
        chk(badr == 0, "R4", "address bit errors", badr, 0);
        if (op) begin
            chk(boe == 0, "R6", "read enable pattern errors", boe, 0);
            chk(nrise == 65, "R6", "read MDC pulses", nrise, 65);
        end else begin
            chk(btail == 0 && boe == 0, "R5", "write tail/enable errors", btail + boe, 0);
            chk(nrise == 66, "R5", "write MDC pulses", nrise, 66);
        end
    endtask

    task automatic issue(input logic op, input logic [4:0] phy,
                         input logic [4:0] ra, input logic [15:0] d);
        req = 1'b1; op_read = op; phy_addr = phy; reg_addr = ra; wdata = d;
    endtask

    task automatic wait_done(output int hc, output int bc);
        int guard = 0;
        hc = 0; bc = 0;
        while (!done && guard < 3000) begin
            if (busy) bc++;
            if (mdc) hc++;
            @(negedge clk);
            guard++;
        end
        if (!done) chk(1'b0, "R8", "done never seen", 0, 1);
    endtask

    task automatic run_frame(input logic op, input logic [4:0] phy,
                             input logic [4:0] ra, input logic [15:0] d);
        int hc, bc, nb;
        nb = op ? 65 : 66;
        cur_read = op; phy_val = d; nrise = 0;
        @(negedge clk); issue(op, phy, ra, d);
        @(negedge clk); req = 1'b0;
        wait_done(hc, bc);
        check_frame(op, phy, ra, d);
        chk(hc == nb * HP, "R7", "MDC high cycles", hc, nb * HP);
        chk(bc == nb * 2 * HP, "R7", "busy cycles", bc, nb * 2 * HP);
        if (op) begin
            chk(rdata == d, "R6", "read result", rdata, d);
            last_rd = d;
        end else begin
            chk(rdata == last_rd, "R8", "rdata after write", rdata, last_rd);
        end
        @(negedge clk);
        chk(!done && !busy, "R8", "done width", {done, busy}, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "R8", "watchdog expired", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int hc, bc;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(!mdc && !mdio_oe && !busy && !done && rdata == 0, "R1", "in reset",
            {mdc, mdio_oe, busy, done, rdata}, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(!mdc && !mdio_oe && !busy && !done && rdata == 0, "R1", "after reset",
            {mdc, mdio_oe, busy, done, rdata}, 0);
        chk(!mdio_oe, "R10", "idle enable", mdio_oe, 0);

        // table-driven frames
        for (int v = 0; v < 6; v++) begin
            run_frame(VEC[v][26], VEC[v][25:21], VEC[v][20:16], VEC[v][15:0]);
            chk(!mdio_oe && !mdc, "R10", "idle between frames", {mdio_oe, mdc}, 0);
        end

        // R9: request mid-frame is dropped
        cur_read = 1'b0; nrise = 0;
        @(negedge clk); issue(1'b0, 5'h03, 5'h04, 16'hC0DE);
        @(negedge clk); req = 1'b0;
        repeat (20) @(negedge clk);
        issue(1'b1, 5'h1C, 5'h1B, 16'h0F0F);
        @(negedge clk); req = 1'b0;
        wait_done(hc, bc);
        check_frame(1'b0, 5'h03, 5'h04, 16'hC0DE);
        chk(rdata == last_rd, "R9", "rdata after dropped read", rdata, last_rd);
        repeat (20) @(negedge clk);
        chk(!busy && nrise == 66, "R9", "no frame from dropped request", nrise, 66);

        // R9: request in the cycle of the final MDC fall is dropped
        cur_read = 1'b0; nrise = 0;
        @(negedge clk); issue(1'b0, 5'h07, 5'h08, 16'hBEEF);
        @(negedge clk); req = 1'b0;
        repeat (66 * 2 * HP - 1) @(negedge clk);
        chk(busy && !done, "R9", "last busy cycle", {busy, done}, 2);
        issue(1'b1, 5'h02, 5'h02, 16'h1111);
        @(negedge clk); req = 1'b0;
        chk(done && !busy, "R8", "done after exact frame length", {done, busy}, 2);
        repeat (10) @(negedge clk);
        chk(!busy && nrise == 66, "R9", "edge request dropped", nrise, 66);
        check_frame(1'b0, 5'h07, 5'h08, 16'hBEEF);

        // R9: request in the done cycle is accepted
        cur_read = 1'b1; phy_val = 16'h7E81; nrise = 0;
        @(negedge clk); issue(1'b1, 5'h09, 5'h0C, 16'h7E81);
        @(negedge clk); req = 1'b0;
        wait_done(hc, bc);
        chk(rdata == 16'h7E81, "R6", "read before back-to-back", rdata, 16'h7E81);
        nrise = 0; cur_read = 1'b0;
        issue(1'b0, 5'h11, 5'h12, 16'h3C5A);
        @(negedge clk); req = 1'b0;
        chk(busy, "R9", "done-cycle request accepted", busy, 1);
        wait_done(hc, bc);
        check_frame(1'b0, 5'h11, 5'h12, 16'h3C5A);
        chk(rdata == 16'h7E81, "R8", "rdata kept over write", rdata, 16'h7E81);

        repeat (5) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule